// File: doc/BRIEF.md
# Resampler Output Stage

This block is the last stage of a sample-rate converter. Samples arrive on the input clock with a valid qualifier. In buffered mode they are written into a dual-clock elastic FIFO and read out on a separate output clock, one read per output-clock cycle. The output clock runs at the resampled rate. When the block leaves reset, the FIFO starts half full, not empty, so the reader has slack on both sides. Because that first half holds no real data, the first outputs after any FIFO reset come out with their valid flag low.

In bypass mode the FIFO is unused. Samples leave on the input clock together with a data-valid strobe that tells downstream logic to take or skip each cycle's word. The strobe polarity can be set to active-high or active-low. The strobe can also be placed one cycle ahead of its data, so that it can drive the clock enable of a device that wants the enable before the data.

The FIFO can be forced back to half full in two ways: by the input-side reset, or by a one-cycle command pulse. The mode bits (bypass, strobe polarity and strobe lead) are captured only while the input-side reset is high.

Top module: `resamp_out_stage`

## Requirements
- R1: Holding `in_rst` high, or pulsing `fifo_reset_cmd` for one `in_clk` cycle, leaves the FIFO at exactly half full (8 of 16 entries). With the reader held in reset, exactly 8 further writes are accepted, and the 9th raises `fifo_ovf`.
- R2: While `in_rst` is high, the FIFO does not move: writes on `in_valid` have no effect, `fifo_ovf` stays low and `out_valid` stays low.
- R3: After a FIFO reset, the first 8 words read out carry `out_valid` low. From then on, written words appear in write order with `out_valid` high, one per `out_clk` cycle.
- R4: A write to a full FIFO is dropped and pulses `fifo_ovf` one `in_clk` cycle later. A read from an empty FIFO leaves `out_data` at the last word read, keeps `out_valid` low and raises `fifo_unf`.
- R5: With bypass selected (`cfg_bypass`=1 at reset), `sync_data` shows `in_data` one `in_clk` cycle after it is sampled, and `out_valid` stays low.
- R6: In bypass, `sync_strobe` equals the registered `in_valid` XOR the polarity bit. With `cfg_strobe_low`=0 the strobe is active-high; with 1 it is active-low. When idle or in reset, the strobe sits at its inactive level.
- R7: With `cfg_strobe_ahead`=1, the strobe for a sample appears one `in_clk` cycle before that sample on `sync_data`. Data latency is then two cycles and strobe latency one.
- R8: The mode inputs are captured only while `in_rst` is high. Changing them afterwards has no effect until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Input sample clock |
| in_rst | input | 1 | Synchronous active-high reset of the input side; also forces the FIFO to half full |
| out_clk | input | 1 | Output (resampled) clock |
| out_rst | input | 1 | Synchronous active-high reset of the read side |
| cfg_bypass | input | 1 | 1 = bypass the FIFO and emit on the input clock |
| cfg_strobe_low | input | 1 | 1 = bypass strobe is active-low |
| cfg_strobe_ahead | input | 1 | 1 = bypass strobe leads its data by one cycle |
| fifo_reset_cmd | input | 1 | One-cycle command that returns the FIFO to half full |
| in_valid | input | 1 | Input sample qualifier |
| in_data | input | 16 | Input sample |
| out_data | output | 16 | Buffered-mode sample on `out_clk` |
| out_valid | output | 1 | Buffered-mode valid flag |
| fifo_ovf | output | 1 | Pulse: a write was dropped because the FIFO was full |
| fifo_unf | output | 1 | Pulse: a read found the FIFO empty |
| sync_data | output | 16 | Bypass-mode sample on `in_clk` |
| sync_strobe | output | 1 | Bypass-mode data-valid strobe |

## Verification
A write pointer that does not land on half full moves the overflow point away from the 9th write after reset, and this shows on `fifo_ovf` within one input cycle of that write. A wrong invalid counter or read pointer changes how many low-valid words come out before the first real one, or changes the order of the words. This is visible within the first 16 output cycles after the reader leaves reset. A mode register that is captured at the wrong time, or a strobe stage that is one cycle off, shows up on the very next input cycle as a strobe level or data word that no longer matches what was driven.

// File: rtl/rso_pkg.sv
package rso_pkg;

    // Placement of the bypass strobe relative to its sample
    typedef enum logic {
        STB_WITH_DATA = 1'b0,
        STB_AHEAD     = 1'b1
    } stb_phase_e;

    // Mode word captured while the input side is in reset
    typedef struct packed {
        logic       bypass;
        logic       strobe_low;
        stb_phase_e phase;
    } out_mode_t;

    // Binary to reflected Gray code; callers cast down to their pointer width
    function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

endpackage

// File: rtl/rso_sync.sv
module rso_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/rso_wctl.sv
module rso_wctl #(
    parameter int AW       = 4,
    parameter int HOLD_CYC = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fifo_cmd,
    input  logic          wr_req,
    input  logic [AW:0]   rgray_s,
    output logic          wr_en,
    output logic [AW-1:0] waddr,
    output logic [AW:0]   wgray,
    output logic          hold_q,
    output logic          ovf
);
    localparam int          PW   = AW + 1;
    localparam int          HW   = $clog2(HOLD_CYC + 1);
    localparam logic [AW:0] HALF = PW'(2 ** (AW - 1));

    logic [HW-1:0] hold_cnt;
    logic [AW:0]   wptr, wptr_nxt;
    logic          holding, full;

    // Reset or a pending command pins the write pointer at half full
    assign holding = rst || (hold_cnt != '0);
    assign full    = (wgray == {~rgray_s[AW:AW-1], rgray_s[AW-2:0]});
    assign wr_en   = wr_req && !full && !holding;
    assign waddr   = wptr[AW-1:0];

    always_comb begin
        if (holding)    wptr_nxt = HALF;
        else if (wr_en) wptr_nxt = wptr + 1'b1;
        else            wptr_nxt = wptr;
    end

    always_ff @(posedge clk) begin
        if (rst)                  hold_cnt <= '0;
        else if (fifo_cmd)        hold_cnt <= HW'(HOLD_CYC);
        else if (hold_cnt != '0)  hold_cnt <= hold_cnt - 1'b1;

        wptr   <= wptr_nxt;
        wgray  <= PW'(rso_pkg::bin_to_gray(32'(wptr_nxt)));
        hold_q <= holding;
        ovf    <= wr_req && full && !holding;
    end
endmodule

// File: rtl/rso_rctl.sv
module rso_rctl #(
    parameter int DW           = 16,
    parameter int AW           = 4,
    parameter int INVALID_OUTS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          halt,
    input  logic [AW:0]   wgray_s,
    input  logic [DW-1:0] rdata,
    output logic [AW-1:0] raddr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] out_data,
    output logic          out_valid,
    output logic          unf
);
    localparam int PW = AW + 1;
    localparam int CW = $clog2(INVALID_OUTS + 1);

    logic [AW:0]   rptr, rptr_nxt;
    logic [CW-1:0] skip_cnt;
    logic          empty, rd_en;

    assign empty    = (rgray == wgray_s);
    assign rd_en    = !halt && !empty;
    assign raddr    = rptr[AW-1:0];
    assign rptr_nxt = rd_en ? rptr + 1'b1 : rptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr      <= '0;
            rgray     <= '0;
            skip_cnt  <= CW'(INVALID_OUTS);
            out_data  <= '0;
            out_valid <= 1'b0;
            unf       <= 1'b0;
        end else begin
            rptr  <= rptr_nxt;
            rgray <= PW'(rso_pkg::bin_to_gray(32'(rptr_nxt)));
            if (rd_en) begin
                out_data <= rdata;
                if (skip_cnt != '0) skip_cnt <= skip_cnt - 1'b1;
            end
            out_valid <= rd_en && (skip_cnt == '0);
            unf       <= !halt && empty;
        end
    end
endmodule

// File: rtl/rso_bypass.sv
module rso_bypass #(
    parameter int DW = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  rso_pkg::out_mode_t mode,
    input  logic               in_valid,
    input  logic [DW-1:0]      in_data,
    output logic [DW-1:0]      sync_data,
    output logic               sync_strobe
);
    logic [DW-1:0] d1, d2;
    logic          v1;

    always_ff @(posedge clk) begin
        if (rst) begin
            d1 <= '0;
            d2 <= '0;
            v1 <= 1'b0;
        end else begin
            d1 <= mode.bypass ? in_data : '0;
            d2 <= d1;
            v1 <= in_valid && mode.bypass;
        end
    end

    // Leading strobe: data takes one more stage than its strobe
    assign sync_data   = (mode.phase == rso_pkg::STB_AHEAD) ? d2 : d1;
    assign sync_strobe = v1 ^ mode.strobe_low;
endmodule

// File: rtl/resamp_out_stage.sv
module resamp_out_stage #(
    parameter int DATA_W       = 16,
    parameter int ADDR_W       = 4,
    parameter int INVALID_OUTS = 8,
    parameter int CMD_HOLD     = 8
) (
    input  logic              in_clk,
    input  logic              in_rst,
    input  logic              out_clk,
    input  logic              out_rst,
    input  logic              cfg_bypass,
    input  logic              cfg_strobe_low,
    input  logic              cfg_strobe_ahead,
    input  logic              fifo_reset_cmd,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] out_data,
    output logic              out_valid,
    output logic              fifo_ovf,
    output logic              fifo_unf,
    output logic [DATA_W-1:0] sync_data,
    output logic              sync_strobe
);
    import rso_pkg::*;

    localparam int              DEPTH     = 1 << ADDR_W;
    localparam int              PW        = ADDR_W + 1;
    localparam logic [ADDR_W:0] HALF_GRAY = PW'(bin_to_gray(32'(DEPTH / 2)));

    out_mode_t         mode_q;
    logic [DATA_W-1:0] mem [DEPTH];
    logic              wr_en, hold_q, hold_s, bypass_s, rst_o;
    logic [ADDR_W-1:0] waddr, raddr;
    logic [ADDR_W:0]   wgray, rgray, wgray_s, rgray_s;

    // Mode word is only taken while the input side is in reset
    always_ff @(posedge in_clk) begin
        if (in_rst) begin
            mode_q.bypass     <= cfg_bypass;
            mode_q.strobe_low <= cfg_strobe_low;
            mode_q.phase      <= stb_phase_e'(cfg_strobe_ahead);
        end
    end

    always_ff @(posedge in_clk) begin
        if (wr_en) mem[waddr] <= in_data;
    end

    rso_wctl #(.AW(ADDR_W), .HOLD_CYC(CMD_HOLD)) u_wctl (
        .clk     (in_clk),
        .rst     (in_rst),
        .fifo_cmd(fifo_reset_cmd),
        .wr_req  (in_valid && !mode_q.bypass),
        .rgray_s (rgray_s),
        .wr_en   (wr_en),
        .waddr   (waddr),
        .wgray   (wgray),
        .hold_q  (hold_q),
        .ovf     (fifo_ovf)
    );

    rso_sync #(.W(PW), .RST_VAL('0)) u_rsync (
        .clk(in_clk), .rst(in_rst), .d(rgray), .q(rgray_s)
    );

    rso_sync #(.W(PW), .RST_VAL(HALF_GRAY)) u_wsync (
        .clk(out_clk), .rst(out_rst), .d(wgray), .q(wgray_s)
    );

    rso_sync #(.W(1), .RST_VAL(1'b0)) u_hsync (
        .clk(out_clk), .rst(out_rst), .d(hold_q), .q(hold_s)
    );

    rso_sync #(.W(1), .RST_VAL(1'b0)) u_bsync (
        .clk(out_clk), .rst(out_rst), .d(mode_q.bypass), .q(bypass_s)
    );

    assign rst_o = out_rst || hold_s;

    rso_rctl #(.DW(DATA_W), .AW(ADDR_W), .INVALID_OUTS(INVALID_OUTS)) u_rctl (
        .clk      (out_clk),
        .rst      (rst_o),
        .halt     (bypass_s),
        .wgray_s  (wgray_s),
        .rdata    (mem[raddr]),
        .raddr    (raddr),
        .rgray    (rgray),
        .out_data (out_data),
        .out_valid(out_valid),
        .unf      (fifo_unf)
    );

    rso_bypass #(.DW(DATA_W)) u_bypass (
        .clk        (in_clk),
        .rst        (in_rst),
        .mode       (mode_q),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .sync_data  (sync_data),
        .sync_strobe(sync_strobe)
    );
endmodule

// File: rtl/rso_checker.sv
module rso_checker #(
    parameter int DATA_W = 16
) (
    input logic              in_clk,
    input logic              in_rst,
    input logic              out_clk,
    input logic              rd_rst,
    input logic              in_valid,
    input logic              fifo_ovf,
    input logic              fifo_unf,
    input logic [DATA_W-1:0] out_data,
    input logic              out_valid,
    input logic              sync_strobe,
    input logic              mode_pol
);
    // R2: a held FIFO never reports a dropped write
    p_hold_no_ovf_r2: assert property (@(posedge in_clk)
        in_rst |=> !fifo_ovf);

    // R3: reader reset always clears the valid flag
    p_no_valid_after_rst_r3: assert property (@(posedge out_clk)
        rd_rst |=> !out_valid);

    // R4: a drop report needs a write attempt in the cycle before
    p_ovf_needs_write_r4: assert property (@(posedge in_clk) disable iff (in_rst)
        fifo_ovf |-> $past(in_valid));

    // R4: an empty read repeats the previous word
    p_repeat_on_empty_r4: assert property (@(posedge out_clk) disable iff (rd_rst)
        fifo_unf |-> ($stable(out_data) && !out_valid));

    // R6: strobe rests at its inactive level through reset
    p_strobe_idle_r6: assert property (@(posedge in_clk)
        in_rst |=> (sync_strobe == mode_pol));
endmodule

bind resamp_out_stage rso_checker #(.DATA_W(DATA_W)) i_chk (
    .in_clk     (in_clk),
    .in_rst     (in_rst),
    .out_clk    (out_clk),
    .rd_rst     (rst_o),
    .in_valid   (in_valid),
    .fifo_ovf   (fifo_ovf),
    .fifo_unf   (fifo_unf),
    .out_data   (out_data),
    .out_valid  (out_valid),
    .sync_strobe(sync_strobe),
    .mode_pol   (mode_q.strobe_low)
);

// File: tb/test_resamp_out_stage.sv
module test_resamp_out_stage;
    logic        in_clk, out_clk, in_rst, out_rst;
    logic        cfg_bypass, cfg_strobe_low, cfg_strobe_ahead, fifo_reset_cmd;
    logic        in_valid;
    logic [15:0] in_data, out_data, sync_data;
    logic        out_valid, fifo_ovf, fifo_unf, sync_strobe;
    int          n_chk = 0;
    int          n_bad = 0;

    // {valid, data} stimulus walked in bypass mode
    localparam logic [16:0] VEC [10] = '{
        17'h1_1234, 17'h0_BEEF, 17'h1_0001, 17'h1_FFFF, 17'h0_0000,
        17'h1_8000, 17'h0_7777, 17'h1_00A5, 17'h1_5A5A, 17'h0_C3C3
    };

    resamp_out_stage i_resamp_out_stage (
        .in_clk(in_clk), .in_rst(in_rst), .out_clk(out_clk), .out_rst(out_rst),
        .cfg_bypass(cfg_bypass), .cfg_strobe_low(cfg_strobe_low),
        .cfg_strobe_ahead(cfg_strobe_ahead), .fifo_reset_cmd(fifo_reset_cmd),
        .in_valid(in_valid), .in_data(in_data), .out_data(out_data),
        .out_valid(out_valid), .fifo_ovf(fifo_ovf), .fifo_unf(fifo_unf),
        .sync_data(sync_data), .sync_strobe(sync_strobe)
    );

    initial begin
        in_clk = 1'b0;
        forever #2 in_clk = ~in_clk;
    end

    initial begin
        out_clk = 1'b0;
        #1;
        forever #2 out_clk = ~out_clk;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Nine writes into a half-full FIFO whose reader is held: only the 9th overflows
    task automatic fill_nine(input logic [15:0] base, input string req);
        for (int i = 1; i <= 9; i++) begin
            in_valid = 1'b1;
            in_data  = base + 16'(i);
            @(negedge in_clk);
            chk(req, 32'(fifo_ovf), 32'(i == 9));
        end
        in_valid = 1'b0;
        @(negedge in_clk);
        chk("R4 ovf is a pulse", 32'(fifo_ovf), 0);
    endtask

    // Release the reader: 8 invalid words, then base+1..base+8, then underflow
    task automatic drain(input logic [15:0] base);
        int          n_inv = 0;
        int          n_val = 0;
        bit          seen  = 0;
        bit          saw_unf = 0;
        logic [15:0] expd  = base + 16'd1;
        @(negedge out_clk);
        out_rst = 1'b0;
        for (int c = 0; c < 30; c++) begin
            @(negedge out_clk);
            if (!seen && !out_valid) n_inv++;
            if (out_valid) begin
                seen = 1;
                chk("R3 word order", 32'(out_data), 32'(expd));
                expd = expd + 16'd1;
                n_val++;
            end
            if (fifo_unf) begin
                saw_unf = 1;
                chk("R4 repeat on empty", {15'd0, out_valid, out_data},
                    {15'd0, 1'b0, base + 16'd8});
            end
        end
        chk("R3 invalid count", 32'(n_inv), 8);
        chk("R3 valid count", 32'(n_val), 8);
        chk("R4 underflow seen", 32'(saw_unf), 1);
    endtask

    task automatic reset_in(input logic byp, input logic pol, input logic ahead);
        @(negedge in_clk);
        in_rst           = 1'b1;
        in_valid         = 1'b0;
        cfg_bypass       = byp;
        cfg_strobe_low   = pol;
        cfg_strobe_ahead = ahead;
        repeat (4) @(negedge in_clk);
        in_rst = 1'b0;
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        in_rst = 1'b1; out_rst = 1'b1;
        cfg_bypass = 1'b0; cfg_strobe_low = 1'b0; cfg_strobe_ahead = 1'b0;
        fifo_reset_cmd = 1'b0; in_valid = 1'b0; in_data = '0;
        repeat (3) @(negedge in_clk);

        // R2: writes during reset are ignored
        in_valid = 1'b1;
        in_data  = 16'hDEAD;
        repeat (3) @(negedge in_clk);
        chk("R2 ovf in reset", 32'(fifo_ovf), 0);
        chk("R2 out_valid in reset", 32'(out_valid), 0);
        chk("R6 idle strobe in reset", 32'(sync_strobe), 0);
        in_valid = 1'b0;
        in_rst   = 1'b0;
        repeat (3) @(negedge in_clk);

        // R1 via reset input, then R3/R4 on the read side
        fill_nine(16'h0A00, "R1 half full after reset");
        drain(16'h0A00);

        // R1 via command pulse: FIFO was full from the reader's view before it
        @(negedge out_clk);
        out_rst = 1'b1;
        repeat (3) @(negedge out_clk);
        @(negedge in_clk);
        fifo_reset_cmd = 1'b1;
        @(negedge in_clk);
        fifo_reset_cmd = 1'b0;
        repeat (12) @(negedge in_clk);
        fill_nine(16'h0B00, "R1 half full after command");
        drain(16'h0B00);

        // R5/R6/R7: bypass vector walk over all strobe modes
        for (int m = 0; m < 4; m++) begin
            logic pol   = m[0];
            logic ahead = m[1];
            reset_in(1'b1, pol, ahead);
            chk("R6 idle strobe level", 32'(sync_strobe), 32'(pol));
            for (int k = 0; k < 10; k++) begin
                in_valid = VEC[k][16];
                in_data  = VEC[k][15:0];
                @(negedge in_clk);
                chk(ahead ? "R7 strobe leads" : "R6 strobe level",
                    32'(sync_strobe), 32'(VEC[k][16] ^ pol));
                if (!ahead)
                    chk("R5 bypass data", 32'(sync_data), 32'(VEC[k][15:0]));
                else if (k >= 1)
                    chk("R7 data one cycle behind strobe", 32'(sync_data),
                        32'(VEC[k-1][15:0]));
            end
            in_valid = 1'b0;
            @(negedge in_clk);
            chk("R6 strobe returns idle", 32'(sync_strobe), 32'(pol));
            chk("R5 out_valid low in bypass", 32'(out_valid), 0);
        end

        // R8: mode changes after reset release have no effect
        reset_in(1'b1, 1'b0, 1'b0);
        cfg_bypass       = 1'b0;
        cfg_strobe_low   = 1'b1;
        cfg_strobe_ahead = 1'b1;
        in_valid = 1'b1;
        in_data  = 16'h3C3C;
        @(negedge in_clk);
        chk("R8 polarity kept", 32'(sync_strobe), 1);
        chk("R8 bypass and timing kept", 32'(sync_data), 32'h3C3C);
        in_valid = 1'b0;
        @(negedge in_clk);
        chk("R8 strobe idle kept", 32'(sync_strobe), 0);

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule